// File: doc/BRIEF.md
# Double-Buffered Timer Channel

This block is a single general-purpose timer channel with three working styles: plain pin control, edge-triggered capture of a time value, and equality-triggered output compare. It picks its time base from one of several shared counter buses or from its own free-running counter. Each edge-triggered capture or compare event raises a sticky event flag. The flag stays set until a clear strobe arrives.

The channel holds two data values, A and B. Each has a working stage (stage 1) and a staging stage (stage 2). Comparisons always use stage 1. Host writes are routed to the stages according to the mode. In pin-control mode a write fills both stages and the own counter is held at zero. In the timer modes a write reaches only stage 2, and stage 2 moves into stage 1 when the time base equals the current stage-1 value. A separate alternate strobe writes stage 2 of A alone in every mode. Software can therefore queue the next compare value without disturbing the one in use.

The pin input passes through a two-flop synchroniser before edge detection. The output pin is driven from a flip-flop.

Top module: `tmr_chan`

## Requirements
- R1: Reset (rst_n low) clears every stage value, the own counter, the event flag, the output pin and the configuration. The configuration then selects pin-input mode, bus 0 and no active edge.
- R2: The mode field has two bits. Bit 1 set selects a timer mode and bit 0 selects output (1) or input (0). So 00 is pin input, 01 is pin output, 10 is capture and 11 is compare. In modes 00 and 01 the own counter is zero after every clock. In modes 10 and 11 it increases by one per clock.
- R3: In modes 00 and 01, a write strobe for A or B stores the write data in both stage 1 and stage 2 of that value.
- R4: The alternate A strobe stores the write data in A stage 2 only, in every mode. A stage 1 is left unchanged.
- R5: In modes 10 and 11, the A and B write strobes store the data in stage 2 only. Stage 1 is left unchanged.
- R6: The comparators detect equality only. In mode 11 the clock after the time base equals A stage 1, A stage 2 is copied into A stage 1. In modes 10 and 11 the clock after the time base equals B stage 1, B stage 2 is copied into B stage 1. A time base above or below the stage-1 value has no effect.
- R7: In mode 11, an A equality sets the output pin to the programmed compare level on the next clock and sets the event flag.
- R8: The clear strobe clears the event flag on the next clock.
- R9: In mode 01, the output pin takes the programmed pin value one clock after the configuration register holds it.
- R10: In mode 10, a selected edge on the pin copies the time base into A stage 1 and sets the event flag. A change of the pin input before clock k is captured at clock k+2.
- R11: The edge field bit 0 enables rising edges and bit 1 enables falling edges. Value 11 enables both edges and value 00 enables neither. A disabled edge does not capture.
- R12: Selector values 0 to 3 choose the corresponding shared bus word, which occupies bits [16*i+15:16*i] of the bus. Any larger selector value chooses the own counter.
- R13: In modes 00 and 01, no pin edge or equality sets the event flag or captures into A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released in step with clk |
| cfg_we | input | 1 | Loads the five configuration fields below |
| cfg_mode | input | 2 | Mode field (see R2) |
| cfg_tb_sel | input | 3 | Time-base selector (see R12) |
| cfg_edge | input | 2 | Edge enables (see R11) |
| cfg_level | input | 1 | Pin level applied on a compare match |
| cfg_gpio_out | input | 1 | Pin value in pin-output mode |
| a_we | input | 1 | Write strobe for A |
| b_we | input | 1 | Write strobe for B |
| alt_a_we | input | 1 | Alternate write strobe, A stage 2 only |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clears the event flag |
| cnt_bus | input | 64 | Four shared counter words |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Output flip-flop |
| flag | output | 1 | Sticky event flag |
| a_stage1 | output | 16 | A stage 1 |
| a_stage2 | output | 16 | A stage 2 |
| b_stage1 | output | 16 | B stage 1 |
| b_stage2 | output | 16 | B stage 2 |
| int_cnt | output | 16 | Own counter |
| pin_sync | output | 1 | Synchronised pin level |

## Verification
Some rules are checked by assertions on every clock. These are:
- the counter held at zero in pin modes and stepping by one in timer modes;
- both stages equal after a pin-mode write;
- A stage 1 untouched by an alternate write;
- the pin following the programmed value in pin-output mode;
- the pin level and flag after a compare equality;
- the flag not rising in pin modes;
- the clear strobe working in pin modes;
- rising and falling edge pulses never occurring together.

Other behaviour is shown only by the bench's scenarios. These are:
- the capture latency of two clocks after synchronisation and the value captured;
- which edge codes do or do not capture;
- staged values moving into stage 1 only on exact equality;
- the choice between a shared bus word and the own counter.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    MODE_PIN_IN  = 2'b00,
    MODE_PIN_OUT = 2'b01,
    MODE_CAPTURE = 2'b10,
    MODE_COMPARE = 2'b11
  } chan_mode_e;

  function automatic logic is_timer(chan_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic rise,
  output logic fall
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall})); // R11

endmodule

// File: rtl/tmr_dbuf.sv
module tmr_dbuf #(
  parameter int W       = 16,
  parameter bit HAS_ALT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_mode,
  input  logic         we,
  input  logic         alt_we,
  input  logic [W-1:0] wr_data,
  input  logic         xfer,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] stage1,
  output logic [W-1:0] stage2
);

  logic [W-1:0] s1_q, s2_q, s1_n, s2_n;
  logic         s2_we;

  generate
    if (HAS_ALT) begin : g_alt
      assign s2_we = we | alt_we;
    end else begin : g_noalt
      assign s2_we = we;
    end
  endgenerate

  always_comb begin
    s2_n = s2_q;
    if (s2_we) s2_n = wr_data;
    s1_n = s1_q;
    if (cap_en)             s1_n = cap_val;
    else if (pin_mode & we) s1_n = wr_data;
    else if (xfer)          s1_n = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_n;
      s2_q <= s2_n;
    end
  end

  assign stage1 = s1_q;
  assign stage2 = s2_q;

  AST_PIN_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && we && !cap_en) |=> (stage1 == stage2)); // R3

  generate
    if (HAS_ALT) begin : g_alt_chk
      AST_ALT_KEEPS_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_we && !we && !cap_en && !xfer) |=> (stage1 == $past(stage1))); // R4
    end
  endgenerate

endmodule

// File: rtl/tmr_tbase.sv
module tmr_tbase #(
  parameter int W    = 16,
  parameter int NBUS = 4,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [NBUS*W-1:0] cnt_bus,
  input  logic [SELW-1:0] sel,
  output logic [W-1:0]    cnt,
  output logic [W-1:0]    tbase
);

  logic [W-1:0] words [NBUS];
  logic [W-1:0] cnt_q, cnt_n;

  generate
    for (genvar i = 0; i < NBUS; i++) begin : g_bus
      assign words[i] = cnt_bus[i*W +: W];
    end
  endgenerate

  always_comb begin
    tbase = cnt_q;
    for (int i = 0; i < NBUS; i++) begin
      if (sel == SELW'(i)) tbase = words[i];
    end
  end

  always_comb cnt_n = run ? cnt_q + W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  AST_CNT_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) + W'(1))); // R2

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter  int W    = 16,
  parameter  int NBUS = 4,
  localparam int SELW = $clog2(NBUS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [SELW-1:0]   cfg_tb_sel,
  input  logic [1:0]        cfg_edge,
  input  logic              cfg_level,
  input  logic              cfg_gpio_out,
  input  logic              a_we,
  input  logic              b_we,
  input  logic              alt_a_we,
  input  logic [W-1:0]      wr_data,
  input  logic              flag_clr,
  input  logic [NBUS*W-1:0] cnt_bus,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              flag,
  output logic [W-1:0]      a_stage1,
  output logic [W-1:0]      a_stage2,
  output logic [W-1:0]      b_stage1,
  output logic [W-1:0]      b_stage2,
  output logic [W-1:0]      int_cnt,
  output logic              pin_sync
);

  chan_mode_e      mode_q, mode_n;
  logic [SELW-1:0] sel_q, sel_n;
  logic [1:0]      edge_q, edge_n;
  logic            level_q, level_n, gout_q, gout_n;
  logic            flag_q, flag_n, pin_q, pin_n;

  logic [W-1:0] tbase;
  logic         timer, pin_mode, rise, fall, fire;
  logic         match_a, match_b, cap_a, set_flag;

  // configuration register
  always_comb begin
    mode_n  = mode_q;
    sel_n   = sel_q;
    edge_n  = edge_q;
    level_n = level_q;
    gout_n  = gout_q;
    if (cfg_we) begin
      mode_n  = chan_mode_e'(cfg_mode);
      sel_n   = cfg_tb_sel;
      edge_n  = cfg_edge;
      level_n = cfg_level;
      gout_n  = cfg_gpio_out;
    end
  end

  assign timer    = is_timer(mode_q);
  assign pin_mode = ~timer;

  tmr_tbase #(.W(W), .NBUS(NBUS), .SELW(SELW)) u_tbase (
    .clk(clk), .rst_n(rst_n), .run(timer), .cnt_bus(cnt_bus),
    .sel(sel_q), .cnt(int_cnt), .tbase(tbase)
  );

  tmr_in_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .level(pin_sync), .rise(rise), .fall(fall)
  );

  assign fire    = (edge_q[0] & rise) | (edge_q[1] & fall);
  assign match_a = (tbase == a_stage1);
  assign match_b = (tbase == b_stage1);
  assign cap_a   = (mode_q == MODE_CAPTURE) & fire;

  tmr_dbuf #(.W(W), .HAS_ALT(1'b1)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .we(a_we),
    .alt_we(alt_a_we), .wr_data(wr_data),
    .xfer((mode_q == MODE_COMPARE) & match_a),
    .cap_en(cap_a), .cap_val(tbase),
    .stage1(a_stage1), .stage2(a_stage2)
  );

  tmr_dbuf #(.W(W), .HAS_ALT(1'b0)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .we(b_we),
    .alt_we(1'b0), .wr_data(wr_data),
    .xfer(timer & match_b),
    .cap_en(1'b0), .cap_val('0),
    .stage1(b_stage1), .stage2(b_stage2)
  );

  // flag and output flip-flop
  always_comb begin
    set_flag = cap_a | ((mode_q == MODE_COMPARE) & match_a);
    flag_n   = flag_q;
    if (set_flag)      flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    pin_n = pin_q;
    if ((mode_q == MODE_COMPARE) & match_a) pin_n = level_q;
    else if (mode_q == MODE_PIN_OUT)        pin_n = gout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PIN_IN;
      sel_q   <= '0;
      edge_q  <= '0;
      level_q <= 1'b0;
      gout_q  <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      sel_q   <= sel_n;
      edge_q  <= edge_n;
      level_q <= level_n;
      gout_q  <= gout_n;
      flag_q  <= flag_n;
      pin_q   <= pin_n;
    end
  end

  assign flag    = flag_q;
  assign pin_out = pin_q;

  AST_PIN_MODE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && !flag) |=> !flag); // R13
  AST_CLEAR_IN_PIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && flag_clr) |=> !flag); // R8
  AST_PIN_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PIN_OUT) |=> (pin_out == $past(gout_q))); // R9
  AST_COMPARE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_COMPARE) && (tbase == a_stage1)) |=> (flag && pin_out == $past(level_q))); // R7

endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_level, cfg_gpio_out;
  logic [1:0]  cfg_mode, cfg_edge;
  logic [2:0]  cfg_tb_sel;
  logic        a_we, b_we, alt_a_we, flag_clr, pin_in;
  logic [15:0] wr_data;
  logic [15:0] busw [4];
  logic [63:0] cnt_bus;
  logic        pin_out, flag, pin_sync;
  logic [15:0] a_stage1, a_stage2, b_stage1, b_stage2, int_cnt;

  assign cnt_bus = {busw[3], busw[2], busw[1], busw[0]};

  always #5 clk = ~clk;

  tmr_chan dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_tb_sel(cfg_tb_sel), .cfg_edge(cfg_edge), .cfg_level(cfg_level),
    .cfg_gpio_out(cfg_gpio_out), .a_we(a_we), .b_we(b_we), .alt_a_we(alt_a_we),
    .wr_data(wr_data), .flag_clr(flag_clr), .cnt_bus(cnt_bus), .pin_in(pin_in),
    .pin_out(pin_out), .flag(flag), .a_stage1(a_stage1), .a_stage2(a_stage2),
    .b_stage1(b_stage1), .b_stage2(b_stage2), .int_cnt(int_cnt), .pin_sync(pin_sync)
  );

  localparam int SIG_A1 = 0, SIG_A2 = 1, SIG_B1 = 2, SIG_B2 = 3,
                 SIG_CNT = 4, SIG_FLAG = 5, SIG_PIN = 6;

  typedef struct {
    string       req;
    int          sig;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  item_t it;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  logic [15:0] act;

  function automatic logic [15:0] pick(int s);
    case (s)
      SIG_A1:   return a_stage1;
      SIG_A2:   return a_stage2;
      SIG_B1:   return b_stage1;
      SIG_B2:   return b_stage2;
      SIG_CNT:  return int_cnt;
      SIG_FLAG: return {15'd0, flag};
      default:  return {15'd0, pin_out};
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it  = q.pop_front();
      act = pick(it.sig);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic expect_v(string req, int sig, logic [15:0] v);
    item_t x;
    x.req = req; x.sig = sig; x.exp = v;
    q.push_back(x);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(logic [1:0] m, logic [2:0] s, logic [1:0] e, logic lv, logic go);
    cfg_mode = m; cfg_tb_sel = s; cfg_edge = e; cfg_level = lv; cfg_gpio_out = go;
    cfg_we = 1'b1; step(1); cfg_we = 1'b0;
  endtask

  task automatic wr_a(logic [15:0] d);
    wr_data = d; a_we = 1'b1; step(1); a_we = 1'b0;
  endtask

  task automatic wr_b(logic [15:0] d);
    wr_data = d; b_we = 1'b1; step(1); b_we = 1'b0;
  endtask

  task automatic wr_alt(logic [15:0] d);
    wr_data = d; alt_a_we = 1'b1; step(1); alt_a_we = 1'b0;
  endtask

  task automatic clr;
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_mode = 0; cfg_tb_sel = 0; cfg_edge = 0; cfg_level = 0; cfg_gpio_out = 0;
    a_we = 0; b_we = 0; alt_a_we = 0; flag_clr = 0; pin_in = 0; wr_data = 0;
    for (int i = 0; i < 4; i++) busw[i] = 16'h0001;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    expect_v("R1", SIG_A1, 0); expect_v("R1", SIG_A2, 0);
    expect_v("R1", SIG_B1, 0); expect_v("R1", SIG_B2, 0);
    expect_v("R1", SIG_CNT, 0); expect_v("R1", SIG_FLAG, 0); expect_v("R1", SIG_PIN, 0);

    // R3 pin-mode writes fill both stages; R2 counter held at zero
    wr_a(16'h1234);
    expect_v("R3", SIG_A1, 16'h1234); expect_v("R3", SIG_A2, 16'h1234);
    wr_b(16'h55AA);
    expect_v("R3", SIG_B1, 16'h55AA); expect_v("R3", SIG_B2, 16'h55AA);
    step(3);
    expect_v("R2", SIG_CNT, 0);
    // R4 alternate write reaches A stage 2 only
    wr_alt(16'h0777);
    expect_v("R4", SIG_A2, 16'h0777); expect_v("R4", SIG_A1, 16'h1234);

    // R9 pin-output mode
    cfg(2'b01, 3'd0, 2'b00, 1'b0, 1'b1);
    expect_v("R9", SIG_PIN, 0);
    step(1);
    expect_v("R9", SIG_PIN, 1);
    cfg(2'b01, 3'd0, 2'b00, 1'b0, 1'b0);
    step(1);
    expect_v("R9", SIG_PIN, 0);

    // compare mode on bus word 1
    wr_a(16'h0040);
    busw[1] = 16'h0010;
    cfg(2'b11, 3'd1, 2'b00, 1'b1, 1'b0);
    expect_v("R2", SIG_CNT, 0);
    step(3);
    expect_v("R2", SIG_CNT, 3);
    wr_a(16'h0099);
    expect_v("R5", SIG_A2, 16'h0099); expect_v("R5", SIG_A1, 16'h0040);
    wr_b(16'h0BBB);
    expect_v("R5", SIG_B2, 16'h0BBB); expect_v("R5", SIG_B1, 16'h55AA);
    busw[1] = 16'h0040;
    step(1);
    busw[1] = 16'h0001;
    expect_v("R6", SIG_A1, 16'h0099);
    expect_v("R7", SIG_PIN, 1); expect_v("R7", SIG_FLAG, 1);
    clr;
    expect_v("R8", SIG_FLAG, 0);
    busw[1] = 16'h55AA;
    step(1);
    busw[1] = 16'h0001;
    expect_v("R6", SIG_B1, 16'h0BBB);
    // R6 equality only: a larger time base does nothing
    cfg(2'b11, 3'd1, 2'b00, 1'b0, 1'b0);
    busw[1] = 16'h0200;
    step(2);
    expect_v("R6", SIG_FLAG, 0); expect_v("R6", SIG_PIN, 1);
    busw[1] = 16'h0099;
    step(1);
    busw[1] = 16'h0001;
    expect_v("R7", SIG_PIN, 0); expect_v("R7", SIG_FLAG, 1);
    wr_alt(16'h0321);
    expect_v("R4", SIG_A2, 16'h0321); expect_v("R4", SIG_A1, 16'h0099);

    // capture mode on bus word 2, rising edge
    clr;
    cfg(2'b10, 3'd2, 2'b01, 1'b0, 1'b0);
    busw[2] = 16'h0ABC;
    pin_in = 1'b1;
    step(2);
    expect_v("R10", SIG_FLAG, 0);
    step(1);
    expect_v("R10", SIG_A1, 16'h0ABC); expect_v("R10", SIG_FLAG, 1);
    // R11 falling edge ignored with rising-only code
    clr;
    busw[2] = 16'h0DEF;
    pin_in = 1'b0;
    step(4);
    expect_v("R11", SIG_A1, 16'h0ABC); expect_v("R11", SIG_FLAG, 0);
    // R11 both edges
    cfg(2'b10, 3'd2, 2'b11, 1'b0, 1'b0);
    busw[2] = 16'h0123;
    pin_in = 1'b1;
    step(3);
    expect_v("R11", SIG_A1, 16'h0123); expect_v("R11", SIG_FLAG, 1);
    // R11 falling only
    clr;
    cfg(2'b10, 3'd2, 2'b10, 1'b0, 1'b0);
    busw[2] = 16'h0456;
    pin_in = 1'b0;
    step(3);
    expect_v("R11", SIG_A1, 16'h0456); expect_v("R11", SIG_FLAG, 1);

    // R13 pin mode: no flag, no capture; R2 counter cleared
    clr;
    cfg(2'b00, 3'd2, 2'b11, 1'b0, 1'b0);
    step(1);
    expect_v("R2", SIG_CNT, 0);
    busw[2] = 16'h0777;
    pin_in = 1'b1;
    step(4);
    expect_v("R13", SIG_A1, 16'h0456); expect_v("R13", SIG_FLAG, 0);
    busw[2] = 16'h0456;
    step(2);
    expect_v("R13", SIG_FLAG, 0);

    // R12 selector above the bus range uses the own counter
    wr_a(16'h0005);
    cfg(2'b11, 3'd4, 2'b00, 1'b1, 1'b0);
    step(5);
    expect_v("R12", SIG_CNT, 5); expect_v("R12", SIG_FLAG, 0);
    step(1);
    expect_v("R12", SIG_FLAG, 1); expect_v("R12", SIG_PIN, 1);
    expect_v("R12", SIG_A1, 16'h0005);

    step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule